// File: doc/BRIEF.md
# I2C Target Register-Memory Controller

This block is the byte-level control layer of an I2C target that exposes a small internal memory to a bus controller. A separate bit-level engine handles the wire protocol. That engine reports five kinds of transaction event to this block as single-cycle pulses: an address match with its direction, a received byte, a request for a byte to transmit, a repeated start, and a stop. The controller answers a transmit request with a byte. It also keeps a sticky set of event flags that the host enables and clears.

A write transaction opens with a memory-address phase of 0 to 4 bytes, sent most significant byte first. The address is reduced modulo the memory depth and latched into a last-address register. The bytes that follow are stored with auto-increment. A read transaction streams bytes out from the current address, again with auto-increment. Both directions wrap from the last location back to zero. When no memory is attached, the controller still reports events, but it discards written bytes. In that case it transmits zero unless the host has enabled the read-request event, in which case it sends the byte the host supplies.

Top module: `i2c_regmem_ctrl`

## Requirements
- R1: After reset the flags, `irq`, `tx_valid`, `cfg_reject` and `last_addr` are zero and the enable mask is 6'h30. Until a legal configuration is accepted, the block ignores every bus event and raises no flag, even with all enables set.
- R2: A configuration is legal when `cfg_addr_bits` is 0, 8, 16, 24 or 32, which sets an address phase of `cfg_addr_bits/8` bytes. A legal configuration returns the block to idle with the current address and `last_addr` at zero. Any other value pulses `cfg_reject` one cycle later and leaves the previous settings in force.
- R3: After a write-direction match, the first N received bytes (N being the configured byte count) form the memory address, most significant byte first. After the last of them, the address modulo DEPTH becomes the current address, and it appears on `last_addr` one cycle later.
- R4: With memory attached, each received byte that is not an address byte is stored at the current address. The current address then advances, and it wraps from DEPTH-1 to 0.
- R5: A transmit request makes `tx_valid` high one cycle later, with `tx_byte` holding the memory byte at the current address. The current address then advances with the same wrap.
- R6: A transmit request that arrives while the address phase is still incomplete first reduces the partial address modulo DEPTH. It then copies that value to `last_addr` and reads from it.
- R7: With a zero-byte address phase, each write transaction stores from address 0. Reads continue from wherever the current address stands.
- R8: A stop, a repeated start or a new address match raises end-read (bit4) if the block was reading. It raises end-write (bit5) if the block was matched for write with no byte yet received, or was writing.
- R9: The event bits are: bit0 read-direction match, bit1 write-direction match, bit2 transmit request, bit3 received byte, bit4 end-read, bit5 end-write. A raised event sets its flag one cycle later only if its enable bit is set, and flags stay set until cleared.
- R10: Writing ones on `flag_clr` clears those flags on the next cycle. `irq` is high exactly when any flag is set.
- R11: With no memory attached, received bytes leave memory unchanged. A transmit request returns 8'h00, or returns `host_tx_byte` when enable bit2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Apply configuration pulse |
| cfg_addr_bits | input | 6 | Memory-address width in bits |
| cfg_mem_present | input | 1 | Memory attached |
| cfg_reject | output | 1 | Illegal configuration seen last cycle |
| ev_match | input | 1 | Own address matched |
| ev_read | input | 1 | Direction of the match, 1 = read |
| ev_rx_valid | input | 1 | Received byte strobe |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_req | input | 1 | Engine requests a byte to transmit |
| ev_restart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop seen |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_byte` answers the last request |
| host_tx_byte | input | 8 | Host byte for reads without memory |
| en_we | input | 1 | Write the enable mask |
| en_wdata | input | 6 | New enable mask |
| flag_clr | input | 6 | Write-one-to-clear flag pulses |
| flags | output | 6 | Sticky enabled event flags |
| irq | output | 1 | Any flag set |
| last_addr | output | 32 | Last selected memory address |

## Verification
Every result is registered once. A flag, `last_addr`, `cfg_reject`, `tx_byte` and `tx_valid` all reflect an input pulse at the first rising edge after it. The bench raises each input on a falling edge, drops it on the next falling edge, and samples right after, so each check reads the value one edge after its stimulus. Memory contents and the expected current address come from an arithmetic model in the bench. The bench sweeps every nonzero address width over several start addresses, including ones beyond the depth, on a 12-entry memory so that both the modulo and the wrap are exercised.

// File: rtl/i2c_regmem_ctrl.sv
module i2c_regmem_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [5:0]  cfg_addr_bits,
  input  logic        cfg_mem_present,
  output logic        cfg_reject,
  input  logic        ev_match,
  input  logic        ev_read,
  input  logic        ev_rx_valid,
  input  logic [7:0]  ev_rx_byte,
  input  logic        ev_tx_req,
  input  logic        ev_restart,
  input  logic        ev_stop,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic [7:0]  host_tx_byte,
  input  logic        en_we,
  input  logic [5:0]  en_wdata,
  input  logic [5:0]  flag_clr,
  output logic [5:0]  flags,
  output logic        irq,
  output logic [31:0] last_addr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [31:0] LEN = 32'(DEPTH);

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_AMR, S_AMW, S_SEL, S_RD, S_WR} st_t;

  st_t         st;
  logic [2:0]  nbytes, cnt;
  logic        mem_on;
  logic [31:0] addr;
  logic [5:0]  en;
  logic [7:0]  mem [DEPTH];

  wire cfg_ok  = (cfg_addr_bits[2:0] == 3'd0) && (cfg_addr_bits <= 6'd32);
  wire cfg_go  = cfg_valid && cfg_ok;
  wire active  = (st != S_OFF);
  wire term    = active && (ev_stop || ev_restart || ev_match);
  wire tx_go   = active && ev_tx_req && !term;
  wire rx_go   = active && ev_rx_valid && !term && !ev_tx_req;
  wire in_sel  = (st == S_AMW) || (st == S_SEL);

  wire [2:0]  cnt_eff = (st == S_AMW) ? nbytes : cnt;
  wire [31:0] base    = (st == S_AMW) ? 32'd0 : addr;
  wire        is_ab   = mem_on && in_sel && (cnt_eff != 3'd0);
  wire [31:0] shifted = {base[23:0], ev_rx_byte};
  wire [31:0] mod_in  = rx_go ? shifted : addr;
  wire [31:0] mod_out = mod_in % LEN;

  wire [31:0] rd_idx  = (st == S_SEL) ? mod_out : addr;
  wire [31:0] rd_next = (rd_idx == LEN - 1) ? 32'd0 : rd_idx + 32'd1;
  wire [31:0] wr_next = (base == LEN - 1) ? 32'd0 : base + 32'd1;

  wire addr_hit = (rx_go && is_ab && cnt_eff == 3'd1) ||
                  (tx_go && mem_on && st == S_SEL);
  wire mem_we   = rx_go && mem_on && !is_ab && !cfg_go;

  wire [5:0] raw;
  assign raw[0] = active && ev_match && ev_read;
  assign raw[1] = active && ev_match && !ev_read;
  assign raw[2] = tx_go;
  assign raw[3] = rx_go;
  assign raw[4] = term && (st == S_RD);
  assign raw[5] = term && ((st == S_AMW) || (st == S_WR));

  assign irq = |flags;

  always_ff @(posedge clk) begin
    if (mem_we) mem[base[AW-1:0]] <= ev_rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_OFF;
      nbytes     <= '0;
      cnt        <= '0;
      mem_on     <= 1'b0;
      addr       <= '0;
      en         <= 6'h30;
      flags      <= '0;
      last_addr  <= '0;
      tx_byte    <= '0;
      tx_valid   <= 1'b0;
      cfg_reject <= 1'b0;
    end else begin
      cfg_reject <= cfg_valid && !cfg_ok;
      tx_valid   <= tx_go;
      flags      <= (flags & ~flag_clr) | (raw & en);
      if (en_we) en <= en_wdata;
      if (cfg_go) begin
        st        <= S_IDLE;
        nbytes    <= cfg_addr_bits[5:3];
        cnt       <= '0;
        mem_on    <= cfg_mem_present;
        addr      <= '0;
        last_addr <= '0;
      end else if (term) begin
        st <= ev_match ? (ev_read ? S_AMR : S_AMW) : S_IDLE;
        if (st == S_SEL) addr <= mod_out;
      end else if (tx_go) begin
        st <= S_RD;
        if (mem_on) begin
          tx_byte <= mem[rd_idx[AW-1:0]];
          addr    <= rd_next;
          if (addr_hit) last_addr <= mod_out;
        end else begin
          tx_byte <= en[2] ? host_tx_byte : 8'h00;
        end
      end else if (rx_go) begin
        if (!mem_on) begin
          st <= S_WR;
        end else if (is_ab) begin
          st  <= S_SEL;
          cnt <= cnt_eff - 3'd1;
          if (addr_hit) begin
            addr      <= mod_out;
            last_addr <= mod_out;
          end else begin
            addr <= shifted;
          end
        end else begin
          addr <= wr_next;
          if (in_sel) st <= S_WR;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regmem_ctrl_chk.sv
module i2c_regmem_ctrl_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic [5:0]  cfg_addr_bits,
  input logic        ev_match,
  input logic        ev_rx_valid,
  input logic        ev_tx_req,
  input logic        ev_restart,
  input logic        ev_stop,
  input logic        tx_valid,
  input logic [5:0]  flag_clr,
  input logic [5:0]  flags,
  input logic        irq,
  input logic [31:0] last_addr,
  input logic [2:0]  st,
  input logic [2:0]  nbytes,
  input logic [31:0] addr,
  input logic [5:0]  en
);
  localparam logic [2:0] C_OFF = 3'd0, C_SEL = 3'd4, C_RD = 3'd5;

  // R5
  tx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_OFF && ev_tx_req && !ev_stop && !ev_restart && !ev_match && !cfg_valid)
      |=> (tx_valid && st == C_RD));

  // R3
  last_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_addr < 32'(DEPTH));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_SEL) |-> (addr < 32'(DEPTH)));

  // R10
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == 6'h3f && !ev_match && !ev_rx_valid && !ev_tx_req && !ev_stop && !ev_restart)
      |=> (flags == 6'h00 && !irq));

  // R2
  cfg_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && (cfg_addr_bits[2:0] != 3'd0 || cfg_addr_bits > 6'd32))
      |=> $stable(nbytes));

  // R8
  end_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RD && ev_stop && en[4] && !cfg_valid) |=> flags[4]);
endmodule

bind i2c_regmem_ctrl i2c_regmem_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr_bits(cfg_addr_bits),
  .ev_match(ev_match), .ev_rx_valid(ev_rx_valid), .ev_tx_req(ev_tx_req),
  .ev_restart(ev_restart), .ev_stop(ev_stop), .tx_valid(tx_valid),
  .flag_clr(flag_clr), .flags(flags), .irq(irq), .last_addr(last_addr),
  .st(st), .nbytes(nbytes), .addr(addr), .en(en)
);

// File: tb/tb_i2c_regmem_ctrl.sv
module tb_i2c_regmem_ctrl;
  localparam int D = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_mem_present = 0;
  logic [5:0] cfg_addr_bits = 0;
  logic cfg_reject;
  logic ev_match = 0, ev_read = 0, ev_rx_valid = 0, ev_tx_req = 0, ev_restart = 0, ev_stop = 0;
  logic [7:0] ev_rx_byte = 0, host_tx_byte = 0, tx_byte;
  logic tx_valid, en_we = 0, irq;
  logic [5:0] en_wdata = 0, flag_clr = 0, flags;
  logic [31:0] last_addr;

  int errs = 0, checks = 0;
  logic [7:0] mm [D];
  int p;
  logic [7:0] rb;
  logic rv;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_regmem_ctrl #(.DEPTH(D)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [5:0] bits, logic mem);
    @(negedge clk); cfg_valid = 1; cfg_addr_bits = bits; cfg_mem_present = mem;
    @(negedge clk); cfg_valid = 0;
  endtask
  task automatic m(logic rd);
    @(negedge clk); ev_match = 1; ev_read = rd;
    @(negedge clk); ev_match = 0;
  endtask
  task automatic rx(logic [7:0] b);
    @(negedge clk); ev_rx_valid = 1; ev_rx_byte = b;
    @(negedge clk); ev_rx_valid = 0;
  endtask
  task automatic tx();
    @(negedge clk); ev_tx_req = 1;
    @(negedge clk); ev_tx_req = 0; rb = tx_byte; rv = tx_valid;
  endtask
  task automatic stp();
    @(negedge clk); ev_stop = 1;
    @(negedge clk); ev_stop = 0;
  endtask
  task automatic rs();
    @(negedge clk); ev_restart = 1;
    @(negedge clk); ev_restart = 0;
  endtask
  task automatic clr();
    @(negedge clk); flag_clr = 6'h3f;
    @(negedge clk); flag_clr = 0;
  endtask
  task automatic set_en(logic [5:0] v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0;
  endtask

  task automatic send_addr(int nb, logic [31:0] a);
    for (int k = 0; k < nb; k++) rx(8'(a >> (8 * (nb - 1 - k))));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] starts [6];
    starts = '{32'd0, 32'd5, 32'd11, 32'd12, 32'd200, 32'h01020304};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 cfg_reject", cfg_reject, 0);
    chk("R1 last_addr", last_addr, 0);
    // R1 inactive: events ignored
    set_en(6'h3f);
    m(0); rx(8'h01); tx(); stp();
    chk("R1 inactive flags", flags, 0);
    chk("R1 inactive tx_valid", rv, 0);
    // R2 illegal while inactive keeps it inactive
    cfg(6'd12, 1);
    chk("R2 reject 12", cfg_reject, 1);
    m(0);
    chk("R2 still inactive", flags, 0);
    set_en(6'h30);
    // R9 default mask: only end-write visible
    cfg(6'd8, 1);
    chk("R2 legal accept", cfg_reject, 0);
    m(0); rx(8'd3); rx(8'h5a); mm[3] = 8'h5a; stp();
    chk("R9 default mask flags", flags, 6'h20);
    chk("R10 irq set", irq, 1);
    clr();
    chk("R10 cleared", flags, 0);
    chk("R10 irq clear", irq, 0);
    // R2 illegal while active keeps one-byte address phase
    cfg(6'd40, 1);
    chk("R2 reject 40", cfg_reject, 1);
    m(0); rx(8'd7);
    chk("R2 width kept", last_addr, 7);
    stp();
    set_en(6'h3f);
    clr();
    // R3 R4 R5 sweep over widths and starts
    for (int nb = 1; nb <= 4; nb++) begin
      cfg(6'(nb * 8), 1);
      for (int s = 0; s < 6; s++) begin
        logic [31:0] a;
        a = (nb == 4) ? starts[s] : (starts[s] & ((32'd1 << (8 * nb)) - 1));
        m(0); send_addr(nb, a);
        chk("R3 last_addr", last_addr, a % D);
        p = a % D;
        for (int i = 0; i < D + 2; i++) begin
          logic [7:0] v;
          v = 8'(nb * 37 + s * 11 + i * 5 + 1);
          rx(v); mm[p] = v; p = (p + 1) % D;
        end
        stp();
        chk("R9 write txn flags", flags, 6'h2a);
        clr();
        m(0); send_addr(nb, a); rs(); m(1);
        p = a % D;
        for (int i = 0; i < D + 2; i++) begin
          tx();
          chk("R5 tx_valid", rv, 1);
          chk("R4 R5 read data", rb, mm[p]);
          p = (p + 1) % D;
        end
        stp();
        chk("R8 read txn flags", flags, 6'h1f);
        clr();
      end
    end
    // R6 short address phase before read
    cfg(6'd16, 1);
    m(0); rx(8'd13); tx();
    chk("R6 short addr data", rb, mm[1]);
    chk("R6 short addr last", last_addr, 1);
    tx();
    chk("R6 next data", rb, mm[2]);
    stp(); clr();
    // R8 new match while reading, then stop while matched for write
    m(0); send_addr(2, 32'd3); rs(); m(1); tx(); clr();
    m(0);
    chk("R8 match ends read", flags, 6'h12);
    stp();
    chk("R8 stop ends write", flags, 6'h32);
    clr();
    // R7 zero-byte address phase
    cfg(6'd0, 1);
    chk("R7 last_addr cleared", last_addr, 0);
    m(0); rx(8'h11); rx(8'h22); rx(8'h33); stp();
    mm[0] = 8'h11; mm[1] = 8'h22; mm[2] = 8'h33;
    m(0); rx(8'h44); stp(); mm[0] = 8'h44;
    m(1); tx();
    chk("R7 read continues", rb, 8'h22);
    tx();
    chk("R7 read next", rb, 8'h33);
    stp(); clr();
    // R11 no memory attached
    cfg(6'd8, 0);
    set_en(6'h30);
    host_tx_byte = 8'ha5;
    m(1); tx();
    chk("R11 zero byte", rb, 8'h00);
    set_en(6'h34);
    tx();
    chk("R11 host byte", rb, 8'ha5);
    stp();
    m(0); rx(8'h00); rx(8'hee); rx(8'hee); stp();
    cfg(6'd8, 1);
    m(0); rx(8'h00); rs(); m(1); tx();
    chk("R11 mem untouched 0", rb, mm[0]);
    tx();
    chk("R11 mem untouched 1", rb, mm[1]);
    stp();
    done = 1;
    finish_run();
  end
endmodule